// File: doc/BRIEF.md
# Decoded Twisted-Ring Timing Generator

This block produces a repeating train of phase strobes for sequencing work inside a larger datapath. A chain of stage flip-flops shifts one place on every enabled clock, and the inverse of the final stage is fed back into the first. With four stages the chain walks through eight distinct codes before it repeats, which is twice the length of a plain rotating one-hot ring built from the same number of flops.

Each code is turned into its own strobe by a single two-input AND of neighbouring stage bits. Every decode term is therefore one gate deep and does not grow with the stage count. The stage bits and the strobes both leave the block. A synchronous reset puts the chain on its first code. No logic steers the chain back from codes outside the sequence, so a reset is the only way into the cycle.

Top module: `johnson_timing_gen`

## Requirements
- R1: While `rst` is high at a rising clock edge, all stages clear to 0 after that edge. Only `tick[0]` is then high. `rst` wins over `en`.
- R2: On an edge with `rst` low and `en` high, `stage_q[0]` takes the inverse of `stage_q[STAGES-1]`, and each `stage_q[i]` for i>0 takes the old `stage_q[i-1]`.
- R3: With the default of four stages, and the stage bits read most-significant first as `stage_q[3:0]`, the enabled sequence from reset is 0000, 0001, 0011, 0111, 1111, 1110, 1100, 1000. After that it returns to 0000.
- R4: On an edge with `rst` low and `en` low, `stage_q` and `tick` keep their values.
- R5: In every code reachable from reset, exactly one bit of `tick` is high.
- R6: `tick[k]` is high for the k-th code of R3, counting from k=0. The terms are as follows. `tick[0]` = ~s0&~s3. `tick[1]` = s0&~s1. `tick[2]` = s1&~s2. `tick[3]` = s2&~s3. `tick[4]` = s0&s3. `tick[5]` = ~s0&s1. `tick[6]` = ~s1&s2. `tick[7]` = ~s2&s3. Here sN means `stage_q[N]`.
- R7: Each enabled edge moves the active strobe up by one position. From `tick[7]` it moves to `tick[0]`.
- R8: `tick` is decoded combinationally from the current `stage_q`. It always belongs to the code shown on `stage_q` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Advance the chain by one stage on this edge |
| stage_q | output | STAGES | Stage flip-flop contents, bit 0 is the first stage |
| tick | output | 2*STAGES | One-hot phase strobes, bit 0 is the first phase |

## Verification
The checker starts judging only after it has seen one reset edge. The chain holds undefined contents until then, and those contents can contain codes that lie outside the sequence. The one-hot, decode and rotation properties assume the stages are always on a legal code. The stimulus keeps to that assumption: it asserts reset first and never forces the stages. It then mixes enabled runs, held stretches and mid-sequence resets, so every code and its wrap are visited several times.

// File: rtl/jc_pkg.sv
package jc_pkg;

  typedef enum logic [1:0] {
    TERM_BOTH_LOW,
    TERM_RISE,
    TERM_BOTH_HIGH,
    TERM_FALL
  } term_kind_e;

  function automatic int jc_phase_count(int stages);
    return 2 * stages;
  endfunction

  // Kind of two-input term that marks phase k of a chain with 'stages' flops
  function automatic term_kind_e jc_term_kind(int k, int stages);
    if (k == 0)          return TERM_BOTH_LOW;
    else if (k < stages) return TERM_RISE;
    else if (k == stages) return TERM_BOTH_HIGH;
    else                 return TERM_FALL;
  endfunction

  // Lower stage index used by the term for phase k
  function automatic int jc_term_lo(int k, int stages);
    if (k == 0 || k == stages) return 0;
    else if (k < stages)       return k - 1;
    else                       return k - stages - 1;
  endfunction

  // Upper stage index used by the term for phase k
  function automatic int jc_term_hi(int k, int stages);
    if (k == 0 || k == stages) return stages - 1;
    else if (k < stages)       return k;
    else                       return k - stages;
  endfunction

endpackage

// File: rtl/jc_stage_reg.sv
module jc_stage_reg #(
  parameter int STAGES = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  output logic [STAGES-1:0] stage_q
);

  // Shift toward the top, inverse of the last stage enters at the bottom
  function automatic logic [STAGES-1:0] twist_shift(input logic [STAGES-1:0] cur);
    return {cur[STAGES-2:0], ~cur[STAGES-1]};
  endfunction

  logic [STAGES-1:0] stage_next;
  logic              advance;

  assign advance    = en & ~rst;
  assign stage_next = twist_shift(stage_q);

  always_ff @(posedge clk) begin
    if (rst)          stage_q <= '0;
    else if (advance) stage_q <= stage_next;
  end

endmodule

// File: rtl/jc_strobe_decode.sv
module jc_strobe_decode #(
  parameter int STAGES = 4,
  localparam int PHASES = jc_pkg::jc_phase_count(STAGES)
) (
  input  logic [STAGES-1:0] stage_q,
  output logic [PHASES-1:0] tick
);
  import jc_pkg::*;

  for (genvar k = 0; k < PHASES; k++) begin : g_phase
    localparam term_kind_e KIND = jc_term_kind(k, STAGES);
    localparam int         LO   = jc_term_lo(k, STAGES);
    localparam int         HI   = jc_term_hi(k, STAGES);
    if (KIND == TERM_BOTH_LOW) begin : g_bl
      assign tick[k] = ~stage_q[LO] & ~stage_q[HI];
    end else if (KIND == TERM_RISE) begin : g_ri
      assign tick[k] =  stage_q[LO] & ~stage_q[HI];
    end else if (KIND == TERM_BOTH_HIGH) begin : g_bh
      assign tick[k] =  stage_q[LO] &  stage_q[HI];
    end else begin : g_fa
      assign tick[k] = ~stage_q[LO] &  stage_q[HI];
    end
  end

endmodule

// File: rtl/johnson_timing_gen.sv
module johnson_timing_gen #(
  parameter int STAGES = 4,
  localparam int PHASES = 2 * STAGES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  output logic [STAGES-1:0] stage_q,
  output logic [PHASES-1:0] tick
);

  logic [STAGES-1:0] stage_w;
  logic [PHASES-1:0] tick_w;

  jc_stage_reg #(.STAGES(STAGES)) u_stages (
    .clk     (clk),
    .rst     (rst),
    .en      (en),
    .stage_q (stage_w)
  );

  jc_strobe_decode #(.STAGES(STAGES)) u_decode (
    .stage_q (stage_w),
    .tick    (tick_w)
  );

  assign stage_q = stage_w;
  assign tick    = tick_w;

endmodule

// File: rtl/jc_timing_chk.sv
module jc_timing_chk #(
  parameter int STAGES = 4,
  localparam int PHASES = 2 * STAGES
) (
  input logic              clk,
  input logic              rst,
  input logic              en,
  input logic [STAGES-1:0] stage_q,
  input logic [PHASES-1:0] tick
);

  logic armed_q = 1'b0;
  always_ff @(posedge clk) if (rst) armed_q <= 1'b1;

  // R1: reset clears every stage and selects the first phase
  p_reset_clears_r1: assert property (@(posedge clk)
    rst |=> (stage_q == '0) && (tick == PHASES'(1)));

  // R2: twisted shift on an enabled edge
  p_twist_shift_r2: assert property (@(posedge clk) disable iff (rst || !armed_q)
    en |=> stage_q == {$past(stage_q[STAGES-2:0]), ~$past(stage_q[STAGES-1])});

  // R4: hold while disabled
  p_hold_r4: assert property (@(posedge clk) disable iff (rst || !armed_q)
    !en |=> $stable(stage_q) && $stable(tick));

  // R5: exactly one strobe in every reachable code
  p_one_strobe_r5: assert property (@(posedge clk) disable iff (rst || !armed_q)
    $countones(tick) == 1);

  // R6 / R8: first phase strobe coincides with the all-zero code
  p_first_phase_r6: assert property (@(posedge clk) disable iff (rst || !armed_q)
    tick[0] == (stage_q == '0));

  // R7: strobe rotates one place per enabled edge
  p_rotate_r7: assert property (@(posedge clk) disable iff (rst || !armed_q)
    en |=> tick == {$past(tick[PHASES-2:0]), $past(tick[PHASES-1])});

endmodule

bind johnson_timing_gen jc_timing_chk #(.STAGES(STAGES)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .en      (en),
  .stage_q (stage_q),
  .tick    (tick)
);

// File: tb/sim_johnson_timing_gen.sv
module sim_johnson_timing_gen;
  localparam int N  = 4;
  localparam int NP = 2 * N;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          en  = 1'b0;
  logic [N-1:0]  stage_q;
  logic [NP-1:0] tick;

  int n_cmp = 0;
  int n_bad = 0;
  int phase = 0;
  bit done  = 1'b0;

  typedef struct {
    logic [N-1:0]  stg;
    logic [NP-1:0] tck;
    string         tag;
  } exp_t;
  exp_t sb[$];

  always #4 clk = ~clk;

  johnson_timing_gen #(.STAGES(N)) u0 (
    .clk(clk), .rst(rst), .en(en), .stage_q(stage_q), .tick(tick)
  );

  // Independent picture of phase k: the count of ones grows from the bottom, then drains from the bottom
  function automatic logic [N-1:0] code_of(int k);
    logic [N-1:0] c;
    for (int i = 0; i < N; i++) c[i] = (k <= N) ? (i < k) : (i >= k - N);
    return c;
  endfunction

  task automatic step(input logic r, input logic e, input string tag);
    exp_t x;
    @(negedge clk);
    rst = r;
    en  = e;
    if (r)      phase = 0;
    else if (e) phase = (phase + 1) % NP;
    x.stg = code_of(phase);
    x.tck = NP'(1) << phase;
    x.tag = tag;
    sb.push_back(x);
  endtask

  // Monitor: compares two time units after each edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (sb.size() > 0) begin
        exp_t x;
        x = sb.pop_front();
        n_cmp++;
        if (stage_q !== x.stg) begin
          n_bad++;
          $display("FAIL %s stage_q actual=%b expected=%b", x.tag, stage_q, x.stg);
        end
        n_cmp++;
        if (tick !== x.tck) begin
          n_bad++;
          $display("FAIL %s/R6/R8 tick actual=%b expected=%b", x.tag, tick, x.tck);
        end
        n_cmp++;
        if ($countones(tick) != 1) begin
          n_bad++;
          $display("FAIL R5 ones in tick actual=%0d expected=1", $countones(tick));
        end
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=expired expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    step(1'b1, 1'b1, "R1");
    step(1'b1, 1'b0, "R1");
    for (int i = 0; i < NP; i++) step(1'b0, 1'b1, "R3");
    step(1'b0, 1'b1, "R7");
    for (int i = 0; i < NP + 3; i++) begin
      step(1'b0, 1'b0, "R4");
      step(1'b0, 1'b0, "R4");
      step(1'b0, 1'b1, "R2");
    end
    for (int i = 0; i < 20; i++) step(1'b0, (i % 3) != 1, "R2");
    step(1'b1, 1'b1, "R1");
    step(1'b0, 1'b0, "R4");
    for (int i = 0; i < 5; i++) step(1'b0, 1'b1, "R3");
    step(1'b1, 1'b0, "R1");
    for (int i = 0; i < 4 * NP; i++) step(1'b0, 1'b1, "R6");
    step(1'b0, 1'b0, "R4");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule